// File: doc/BRIEF.md
# Sliding 3D Stencil Window Former

This block turns a stream of grid values into stencil neighbourhoods for a three-dimensional grid that is walked one X slice at a time. A slice is a block of rows in Y, and each row is a column of levels in Z. Values are opaque 64-bit words. They arrive one per cycle over a valid/ready stream, with Y as the outer loop and Z as the inner loop of each slice. The slice that is arriving always holds the plane at x+1 of the point being emitted.

Two on-chip banks hold the two most recent complete slices. One bank holds the current slice (x). The other bank holds the slice before it (x-1). It is also overwritten in place by the arriving slice (x+1), because each of its words is read for the last time in the same cycle that the matching incoming word replaces it. At the end of every slice the roles of the two banks swap through a single pointer bit, so no data is copied. Each accepted input at level z ≥ 1 yields one record for the point (x, y, z), and that record leaves through a single output register. The first slice after reset only fills a bank.

The Y and Z extents of a slice come from configuration inputs. A run lasts from one reset to the next.

Top module: `stencil_window_former`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: While the first slice after reset is being accepted, no record is emitted and inReady stays 1.
- R3: From the second slice on, every accepted input at level z ≥ 1 yields exactly one record, and inputs at z = 0 yield none. Records leave in input order, so a run of S slices gives (S-1)·Ysize·(Zsize-1) records with no loss or duplication.
- R4: A record for point (x,y,z) packs seven 64-bit fields:
  - bits 63:0 hold the centre (x,y,z);
  - bits 127:64 hold (x,y,z-1);
  - bits 191:128 hold (x,y,z+1);
  - bits 255:192 hold (x,y+1,z);
  - bits 319:256 hold (x+1,y,z), which is the input accepted in that cycle;
  - bits 383:320 hold (x-1,y,z);
  - bits 447:384 hold the diagonal (x-1,y,z+1).
- R5: An input that would produce a record is not accepted while a record is held and outReady is 0. Such an input is accepted in the same cycle that the held record leaves. Inputs that produce no record are accepted regardless of outReady.
- R6: While outValid is 1 and outReady is 0, outValid stays 1 and the record does not change.
- R7: At the top level (z = Zsize-1), the z+1 field and the diagonal field are zero and the pad flag (bit 448) is 1.
- R8: In the last row of the slice (y = Ysize-1), the y+1 field is zero and bit 448 is 1.
- R9: For records of the first emitted slice (x = 0), the x-1 field and the diagonal field are zero and bit 448 is 1.
- R10: Bit 448 is 0 for every record that has all of its neighbours inside the grid.
- R11: Throughput is one input accepted and one record emitted per cycle whenever inValid and outReady are both held high. This holds for any extent from 1 to MAX_Y rows and from 2 to MAX_Z levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, starts a new run |
| cfgSizeY | input | $clog2(MAX_Y+1) | Rows per slice (1..MAX_Y) |
| cfgSizeZ | input | $clog2(MAX_Z+1) | Levels per row (2..MAX_Z) |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inData | input | 64 | Grid value |
| outValid | output | 1 | Record valid |
| outReady | input | 1 | Consumer takes the record when high with outValid |
| outRecord | output | 449 | Packed neighbourhood record with pad flag in bit 448 |

## Verification
The assertions assume that cfgSizeY and cfgSizeZ stay constant and inside their legal ranges while rstN is high. The coordinate-range check in particular relies on this. They also assume that a run's extents are changed only under reset. The bench respects this by loading new extents only while rstN is low. The data and handshake inputs are left free. Valid gaps and ready stalls are random, and long forced stalls of the consumer exercise the hold and backpressure properties.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

  localparam int DATA_W = 64;

  typedef logic [DATA_W-1:0] word_t;

  // Field order fixes the bit positions of the record (centre in the LSBs).
  typedef struct packed {
    logic  pad;
    word_t diag;
    word_t xMinus;
    word_t xPlus;
    word_t yPlus;
    word_t zPlus;
    word_t zMinus;
    word_t centre;
  } stencil_rec_t;

  localparam int REC_W = $bits(stencil_rec_t);

  // Strobes from control to datapath
  typedef struct packed {
    logic write;    // store inData into the non-current bank
    logic emit;     // load the output register with a new record
    logic curBank;  // bank holding slice x
    logic edgeY;    // point sits in the last row
    logic edgeZ;    // point sits at the top level
    logic noPrev;   // slice x-1 does not exist yet
  } stencil_strobe_t;

endpackage

// File: rtl/stencil_ctrl.sv
module stencil_ctrl
  import stencil_pkg::*;
#(
  parameter int MAX_Y = 8,
  parameter int MAX_Z = 16,
  localparam int YW = (MAX_Y > 1) ? $clog2(MAX_Y) : 1,
  localparam int ZW = $clog2(MAX_Z),
  localparam int CYW = $clog2(MAX_Y + 1),
  localparam int CZW = $clog2(MAX_Z + 1),
  localparam int DEPTH = MAX_Y * MAX_Z,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CYW-1:0]  cfgSizeY,
  input  logic [CZW-1:0]  cfgSizeZ,
  input  logic            inValid,
  input  logic            outReady,
  input  logic            outValid,
  output logic            inReady,
  output stencil_strobe_t strobe,
  output logic [AW-1:0]   addrCentre,
  output logic [AW-1:0]   addrZm,
  output logic [AW-1:0]   addrZp,
  output logic [AW-1:0]   addrYp
);

  localparam logic [AW-1:0] STRIDE = AW'(MAX_Z);

  logic [YW-1:0] yIdx;
  logic [ZW-1:0] zIdx;
  logic curBank, haveCur, havePrev;
  logic lastY, lastZ, wantsOut, accept;
  logic [AW-1:0] rowBase;

  assign lastY = (CYW'(yIdx) == cfgSizeY - CYW'(1));
  assign lastZ = (CZW'(zIdx) == cfgSizeZ - CZW'(1));

  // An input only produces a record once slice x is buffered and z is not 0
  assign wantsOut = haveCur && (zIdx != '0);
  assign inReady  = !wantsOut || !outValid || outReady;
  assign accept   = inValid && inReady;

  assign rowBase    = AW'(yIdx) * STRIDE;
  assign addrCentre = rowBase + AW'(zIdx);
  // Clamp neighbour addresses at the slice edges; the datapath zeroes them
  assign addrZm = (zIdx == '0) ? addrCentre : addrCentre - AW'(1);
  assign addrZp = lastZ ? addrCentre : addrCentre + AW'(1);
  assign addrYp = lastY ? addrCentre : addrCentre + STRIDE;

  always_comb begin
    strobe.write   = accept;
    strobe.emit    = accept && wantsOut;
    strobe.curBank = curBank;
    strobe.edgeY   = lastY;
    strobe.edgeZ   = lastZ;
    strobe.noPrev  = !havePrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yIdx     <= '0;
      zIdx     <= '0;
      curBank  <= 1'b0;
      haveCur  <= 1'b0;
      havePrev <= 1'b0;
    end else if (accept) begin
      if (lastZ) begin
        zIdx <= '0;
        if (lastY) begin
          yIdx     <= '0;
          curBank  <= ~curBank;  // rotate slices down in X
          haveCur  <= 1'b1;
          havePrev <= haveCur;
        end else begin
          yIdx <= yIdx + YW'(1);
        end
      end else begin
        zIdx <= zIdx + ZW'(1);
      end
    end
  end

  // Walk position stays within the configured slice extents
  assert_coord_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (CYW'(yIdx) < cfgSizeY) && (CZW'(zIdx) < cfgSizeZ));

endmodule

// File: rtl/stencil_datapath.sv
module stencil_datapath
  import stencil_pkg::*;
#(
  parameter int MAX_Y = 8,
  parameter int MAX_Z = 16,
  localparam int DEPTH = MAX_Y * MAX_Z,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  stencil_strobe_t strobe,
  input  logic [AW-1:0]   addrCentre,
  input  logic [AW-1:0]   addrZm,
  input  logic [AW-1:0]   addrZp,
  input  logic [AW-1:0]   addrYp,
  input  word_t           inData,
  input  logic            outReady,
  output logic            outValid,
  output stencil_rec_t    outRecord
);

  logic [1:0][DATA_W-1:0] rdC, rdZm, rdZp, rdYp;

  for (genvar b = 0; b < 2; b++) begin : gBank
    word_t mem [DEPTH];
    always_ff @(posedge clk) begin
      // The incoming slice overwrites x-1 in place, after its last read
      if (strobe.write && (strobe.curBank != 1'(b)))
        mem[addrCentre] <= inData;
    end
    assign rdC[b]  = mem[addrCentre];
    assign rdZm[b] = mem[addrZm];
    assign rdZp[b] = mem[addrZp];
    assign rdYp[b] = mem[addrYp];
  end

  stencil_rec_t nextRec;
  logic prevSel;

  assign prevSel = ~strobe.curBank;

  always_comb begin
    nextRec.centre = rdC[strobe.curBank];
    nextRec.zMinus = rdZm[strobe.curBank];
    nextRec.zPlus  = strobe.edgeZ ? '0 : rdZp[strobe.curBank];
    nextRec.yPlus  = strobe.edgeY ? '0 : rdYp[strobe.curBank];
    nextRec.xPlus  = inData;
    nextRec.xMinus = strobe.noPrev ? '0 : rdC[prevSel];
    nextRec.diag   = (strobe.noPrev || strobe.edgeZ) ? '0 : rdZp[prevSel];
    nextRec.pad    = strobe.edgeZ || strobe.edgeY || strobe.noPrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outRecord <= '0;
    end else if (strobe.emit) begin
      outValid  <= 1'b1;
      outRecord <= nextRec;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // A held record must not be replaced or withdrawn
  assert_hold_record_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outRecord)));

  // Control never emits over a record that is still waiting
  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> (!outValid || outReady));

  // Every emit strobe becomes a visible record
  assert_emit_visible_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> outValid);

  // Boundary substitution leaves the pad flag set
  assert_pad_on_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && (strobe.edgeZ || strobe.edgeY || strobe.noPrev)) |=> outRecord.pad);

endmodule

// File: rtl/stencil_window_former.sv
module stencil_window_former
  import stencil_pkg::*;
#(
  parameter int MAX_Y = 8,
  parameter int MAX_Z = 16,
  localparam int CYW = $clog2(MAX_Y + 1),
  localparam int CZW = $clog2(MAX_Z + 1),
  localparam int AW = $clog2(MAX_Y * MAX_Z)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CYW-1:0]    cfgSizeY,
  input  logic [CZW-1:0]    cfgSizeZ,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [REC_W-1:0]  outRecord
);

  stencil_strobe_t strobe;
  stencil_rec_t    recQ;
  logic [AW-1:0]   addrCentre, addrZm, addrZp, addrYp;

  stencil_ctrl #(.MAX_Y(MAX_Y), .MAX_Z(MAX_Z)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgSizeY(cfgSizeY), .cfgSizeZ(cfgSizeZ),
    .inValid(inValid), .outReady(outReady), .outValid(outValid),
    .inReady(inReady), .strobe(strobe),
    .addrCentre(addrCentre), .addrZm(addrZm), .addrZp(addrZp), .addrYp(addrYp)
  );

  stencil_datapath #(.MAX_Y(MAX_Y), .MAX_Z(MAX_Z)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .addrCentre(addrCentre), .addrZm(addrZm), .addrZp(addrZp), .addrYp(addrYp),
    .inData(inData), .outReady(outReady),
    .outValid(outValid), .outRecord(recQ)
  );

  assign outRecord = recQ;

endmodule

// File: tb/stencil_window_former_test.sv
module stencil_window_former_test;

  localparam int MAX_Y = 8;
  localparam int MAX_Z = 16;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN;
  logic [3:0] cfgSizeY;
  logic [4:0] cfgSizeZ;
  logic inValid, inReady, outValid, outReady;
  logic [63:0] inData;
  logic [448:0] outRecord;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit timedOut = 0;

  always #10 clk = ~clk;

  stencil_window_former #(.MAX_Y(MAX_Y), .MAX_Z(MAX_Z)) uut (
    .clk(clk), .rstN(rstN), .cfgSizeY(cfgSizeY), .cfgSizeZ(cfgSizeZ),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outRecord(outRecord)
  );

  function automatic logic [63:0] gridVal(int salt, int x, int y, int z);
    return {8'hC5, 8'(salt), 16'(x), 16'(y), 16'(z)};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareRecord(int k, int ny, int nz, int salt);
    int pts, x, r, y, z;
    logic [63:0] e [7];
    bit topZ, topY, firstX, expPad;
    pts = ny * (nz - 1);
    x = k / pts; r = k % pts; y = r / (nz - 1); z = r % (nz - 1) + 1;
    topZ = (z == nz - 1); topY = (y == ny - 1); firstX = (x == 0);
    e[0] = gridVal(salt, x, y, z);
    e[1] = gridVal(salt, x, y, z - 1);
    e[2] = topZ ? 64'd0 : gridVal(salt, x, y, z + 1);
    e[3] = topY ? 64'd0 : gridVal(salt, x, y + 1, z);
    e[4] = gridVal(salt, x + 1, y, z);
    e[5] = firstX ? 64'd0 : gridVal(salt, x - 1, y, z);
    e[6] = (firstX || topZ) ? 64'd0 : gridVal(salt, x - 1, y, z + 1);
    expPad = topZ || topY || firstX;
    check(outRecord[63:0] == e[0], "R4 centre", outRecord[63:0], e[0]);
    check(outRecord[127:64] == e[1], "R4 z-1", outRecord[127:64], e[1]);
    check(outRecord[191:128] == e[2], topZ ? "R7 z+1" : "R4 z+1", outRecord[191:128], e[2]);
    check(outRecord[255:192] == e[3], topY ? "R8 y+1" : "R4 y+1", outRecord[255:192], e[3]);
    check(outRecord[319:256] == e[4], "R4 x+1", outRecord[319:256], e[4]);
    check(outRecord[383:320] == e[5], firstX ? "R9 x-1" : "R4 x-1", outRecord[383:320], e[5]);
    check(outRecord[447:384] == e[6], (firstX || topZ) ? "R9 R7 diag" : "R4 diag",
          outRecord[447:384], e[6]);
    check(outRecord[448] == expPad, expPad ? "R7 R8 R9 pad" : "R10 pad",
          {63'd0, outRecord[448]}, {63'd0, expPad});
  endtask

  // mode 0: random handshakes with periodic forced stalls; mode 1: both sides always ready
  task automatic runCase(int ny, int nz, int slices, int mode);
    int totalIn, totalOut, accIn, gotOut, drain, cyc, salt, fullRun;
    bit prevStall;
    logic [448:0] prevRec;
    salt = int'($urandom_range(255));
    totalIn = slices * ny * nz;
    totalOut = (slices - 1) * ny * (nz - 1);
    accIn = 0; gotOut = 0; drain = 0; cyc = 0; fullRun = 0;
    prevStall = 0; prevRec = '0;
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0; inData = '0;
    cfgSizeY = 4'(ny); cfgSizeZ = 5'(nz);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #5;
    check(outValid == 1'b0, "R1 outValid", {63'd0, outValid}, 64'd0);
    check(inReady == 1'b1, "R1 inReady", {63'd0, inReady}, 64'd1);
    while ((accIn < totalIn || gotOut < totalOut || drain < 4) && !timedOut) begin
      @(negedge clk);
      if (mode == 1) begin
        inValid = (accIn < totalIn);
        outReady = 1'b1;
      end else begin
        inValid = (accIn < totalIn) && ($urandom_range(3) != 0);
        outReady = ((cyc % 50) >= 30 && (cyc % 50) < 42) ? 1'b0 : ($urandom_range(2) != 0);
      end
      if (inValid) begin
        int sl = ny * nz;
        inData = gridVal(salt, accIn / sl, (accIn % sl) / nz, accIn % nz);
      end else begin
        inData = {$urandom, $urandom};
      end
      #5;
      if (prevStall)
        check(outValid && (outRecord == prevRec), "R6 hold", outRecord[63:0], prevRec[63:0]);
      if (accIn <= ny * nz + 1)
        check(!outValid, "R2 no output", {63'd0, outValid}, 64'd0);
      if (accIn < ny * nz)
        check(inReady, "R2 ready", {63'd0, inReady}, 64'd1);
      if (accIn < totalIn) begin
        bit nextEmits = (accIn >= ny * nz) && (accIn % nz != 0);
        if (nextEmits && outValid && !outReady)
          check(!inReady, "R5 stall", {63'd0, inReady}, 64'd0);
        else
          check(inReady, "R5 accept", {63'd0, inReady}, 64'd1);
      end
      if (mode == 1 && accIn > ny * nz + 1 && accIn < totalIn && (accIn % nz) > 1) begin
        fullRun++;
        check(outValid && inReady, "R11 full rate", {62'd0, outValid, inReady}, 64'd3);
      end
      if (outValid && outReady) begin
        if (gotOut >= totalOut)
          check(1'b0, "R3 extra record", 64'(gotOut + 1), 64'(totalOut));
        else
          compareRecord(gotOut, ny, nz, salt);
        gotOut++;
      end
      if (inValid && inReady) accIn++;
      prevStall = outValid && !outReady;
      prevRec = outRecord;
      if (accIn == totalIn && gotOut >= totalOut) drain++;
      cyc++;
      cycles++;
      if (cycles > LIMIT) timedOut = 1;
    end
    check(gotOut == totalOut, "R3 record count", 64'(gotOut), 64'(totalOut));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0;
    inValid = 1'b0;
    outReady = 1'b0;
    inData = '0;
    cfgSizeY = 4'd3;
    cfgSizeZ = 5'd5;
    runCase(3, 5, 4, 0);
    runCase(MAX_Y, MAX_Z, 3, 0);   // largest extents
    runCase(1, 2, 4, 0);           // smallest extents
    runCase(4, 6, 3, 1);           // R11 full-rate streaming
    runCase(5, 3, 5, 0);
    if (timedOut) begin
      miscompares++;
      $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", cycles, LIMIT);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule